// File: doc/BRIEF.md
# Fixed-Point Escape-Time Iteration Engine

This block measures how many steps one point of the complex plane survives under the quadratic map z ← z² + c, with z starting at zero. The caller presents a signed real and imaginary coordinate and an iteration limit, then pulses `start`. The engine runs the recurrence in two's-complement fixed point, counts the steps and returns the count with a one-cycle `done` pulse. A pixel generator wraps one or more of these engines and turns the counts into picture values.

The loop follows a do-while shape. The first update always happens. The counter rises with every update. The stop test runs only after the update, and it combines the size of the point with the count limit. Each iteration takes two clock cycles. In the first cycle the three products of the current z are registered. In the second the stop test is made on those products and, when the loop goes on, the new z is written from them.

Top module: `escape_engine`

## Requirements
- R1: Coordinates and z use signed Q4.28 (32 bits, 1.0 = 2^28). One update computes newRe = low32((zr·zr − zi·zi) >>> 28) + cRe and newIm = low32((zr·zi) >>> 27) + cIm. Both use the old zr and zi, the shifts are arithmetic on full-width products, and the additions wrap modulo 2^32. The reported count matches a reference built on this arithmetic.
- R2: zr and zi are zero when the first update of every point begins, whatever the previous point left behind.
- R3: At least one update is always made, so the count is never below 1. This holds with a limit of 0, and for a point whose first update already lands outside the radius.
- R4: After each update the squared magnitude zr²+zi² of the new z is formed at full product width (Q8.56, computed without wrap) and compared with 4.0. The loop stops when it is not below 4.0 or when the count is not below the limit. A point whose first iterate reaches magnitude ≥ 2 (for example c = 7.0, c = 2.0 or c = −2.0) returns 1.
- R5: A point that never escapes (the origin, c = −1.0) returns exactly the limit. Limits up to 2^17−1 are supported.
- R6: `start` is taken only while `busy` is low. `busy` is high from the next cycle until the result is ready. `done` is a one-cycle pulse, and `busy` is already low in that cycle.
- R7: `kOut` carries the count in the cycle `done` is high and keeps it unchanged until the next result.
- R8: A `start` pulse while `busy` is high has no effect. The running point finishes with its own coordinate and limit.
- R9: `done` is high in the cycle that follows the 2k+2-th rising edge after the edge that takes `start`, where k is the reported count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new point (taken only when idle) |
| cReal | input | 32 | Real part of c, signed Q4.28 |
| cImag | input | 32 | Imaginary part of c, signed Q4.28 |
| iterLimit | input | 17 | Largest count allowed |
| busy | output | 1 | A point is being iterated |
| done | output | 1 | One-cycle pulse, result valid |
| kOut | output | 17 | Escape-time count |

## Verification
The assertions guard the properties that hold cycle by cycle. They check that z is zero after a load, that the squares stay non-negative, that the count never goes past the limit unless the limit is 0, and that the result is never 0. They also check the shape of the busy/done handshake, that `kOut` holds between results, and that the captured limit does not change while a point runs. Whether the arithmetic is right can only be shown by the bench scenarios. The bench compares counts with an independent bit-accurate model over random points and directed boundaries (origin, far point, radius edge, limit 0), and also checks latency and a start pulse that lands mid-run.

// File: rtl/escape_pkg.sv
package escape_pkg;
  // strobes sent from the sequencer to the arithmetic
  typedef struct packed {
    logic load;    // capture c, clear z
    logic mulEn;   // register the three products of current z
    logic update;  // write new z from registered products
  } dpCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_EVAL = 2'd2
  } engState_t;
endpackage

// File: rtl/escape_datapath.sv
module escape_datapath
  import escape_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 28
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic signed [W-1:0] cRealIn,
  input  logic signed [W-1:0] cImagIn,
  output logic                escaped
);
  localparam int PW = 2 * W;
  localparam logic [PW:0] RADIUS_SQ = (PW+1)'(4) << (2 * FRAC);

  logic signed [W-1:0]  cRe, cIm, zRe, zIm;
  logic signed [PW-1:0] pRR, pII, pRI;
  logic signed [PW:0]   diffWide, diffShift;
  logic signed [PW-1:0] crossShift;
  logic signed [W-1:0]  newRe, newIm;
  logic [PW:0]          magSq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cRe <= '0; cIm <= '0; zRe <= '0; zIm <= '0;
      pRR <= '0; pII <= '0; pRI <= '0;
    end else begin
      if (cmd.load) begin
        cRe <= cRealIn;
        cIm <= cImagIn;
        zRe <= '0;
        zIm <= '0;
      end else if (cmd.update) begin
        zRe <= newRe;
        zIm <= newIm;
      end
      if (cmd.mulEn) begin
        pRR <= zRe * zRe;
        pII <= zIm * zIm;
        pRI <= zRe * zIm;
      end
    end
  end

  always_comb begin
    diffWide   = {pRR[PW-1], pRR} - {pII[PW-1], pII};
    diffShift  = diffWide >>> FRAC;
    crossShift = pRI >>> (FRAC - 1);
    newRe      = diffShift[W-1:0] + cRe;
    newIm      = crossShift[W-1:0] + cIm;
    magSq      = {1'b0, pRR} + {1'b0, pII};
    escaped    = (magSq >= RADIUS_SQ);
  end

  // R2
  z_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.load) |-> (zRe == '0 && zIm == '0));

  // R4
  square_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pRR[PW-1] == 1'b0 && pII[PW-1] == 1'b0));
endmodule

// File: rtl/escape_ctrl.sv
module escape_ctrl
  import escape_pkg::*;
#(
  parameter int KW = 17
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [KW-1:0] limitIn,
  input  logic          escaped,
  output dpCmd_t        cmd,
  output logic          busy,
  output logic          done,
  output logic [KW-1:0] kOut
);
  engState_t     state;
  logic [KW-1:0] kCnt, limitReg;
  logic          firstPass, keepGoing;

  always_comb begin
    firstPass  = (kCnt == '0);
    keepGoing  = firstPass || (!escaped && (kCnt < limitReg));
    cmd.load   = (state == ST_IDLE) && start;
    cmd.mulEn  = (state == ST_MUL);
    cmd.update = (state == ST_EVAL) && keepGoing;
    busy       = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kCnt     <= '0;
      limitReg <= '0;
      kOut     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          limitReg <= limitIn;
          kCnt     <= '0;
          state    <= ST_MUL;
        end
        ST_MUL: state <= ST_EVAL;
        ST_EVAL: begin
          if (keepGoing) begin
            kCnt  <= kCnt + 1'b1;
            state <= ST_MUL;
          end else begin
            kOut  <= kCnt;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(kOut));

  // R3
  nonzero_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (kOut != '0));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (kCnt <= limitReg || kCnt == KW'(1)));

  // R8
  limit_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(limitReg));
endmodule

// File: rtl/escape_engine.sv
module escape_engine
  import escape_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 28,
  parameter int KW   = 17
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic signed [W-1:0] cReal,
  input  logic signed [W-1:0] cImag,
  input  logic [KW-1:0]       iterLimit,
  output logic                busy,
  output logic                done,
  output logic [KW-1:0]       kOut
);
  dpCmd_t cmd;
  logic   escaped;

  escape_ctrl #(.KW(KW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .limitIn(iterLimit),
    .escaped(escaped), .cmd(cmd), .busy(busy), .done(done), .kOut(kOut)
  );

  escape_datapath #(.W(W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cRealIn(cReal), .cImagIn(cImag),
    .escaped(escaped)
  );
endmodule

// File: tb/tb_escape_engine.sv
`timescale 1ns/1ps
module tb_escape_engine;
  localparam int KW  = 17;
  localparam int ONE = 1 << 28;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic signed [31:0] cReal = '0, cImag = '0;
  logic [KW-1:0] iterLimit = '0;
  logic busy, done;
  logic [KW-1:0] kOut;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  escape_engine dut (
    .clk(clk), .rstN(rstN), .start(start), .cReal(cReal), .cImag(cImag),
    .iterLimit(iterLimit), .busy(busy), .done(done), .kOut(kOut)
  );

  function automatic int refK(input int cr, input int ci, input int lim);
    logic signed [31:0] zr = 0, zi = 0, nr, ni;
    longint rr, ii, ri, t1, t2;
    logic [64:0] mag;
    int k = 0;
    logic [64:0] rad = 65'd1 << 58;
    do begin
      rr = longint'(zr) * longint'(zr);
      ii = longint'(zi) * longint'(zi);
      ri = longint'(zr) * longint'(zi);
      t1 = (rr - ii) >>> 28;
      t2 = ri >>> 27;
      nr = t1[31:0] + cr;
      ni = t2[31:0] + ci;
      zr = nr; zi = ni;
      k++;
      rr = longint'(zr) * longint'(zr);
      ii = longint'(zi) * longint'(zi);
      mag = {1'b0, rr} + {1'b0, ii};
    end while (mag < rad && k < lim);
    return k;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one point; if intrude, pulses start with other values mid-run (R8)
  task automatic runPoint(input int cr, input int ci, input int lim,
                          input string tag, input bit intrude);
    int expK, n;
    expK = refK(cr, ci, lim);
    @(negedge clk);
    start = 1'b1; cReal = cr; cImag = ci; iterLimit = KW'(lim);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R6 busy after start", longint'(busy), 1);
    n = 0;
    while (done !== 1'b1 && n < 300000) begin
      @(negedge clk);
      n++;
      if (intrude && n == 2) begin
        start = 1'b1; cReal = 32'sh10000000; cImag = 0; iterLimit = KW'(1);
      end else if (intrude && n == 3) begin
        start = 1'b0;
      end
    end
    check(kOut == KW'(expK), tag, longint'(kOut), longint'(expK));
    check(n == 2 * expK + 2, "R9 latency", longint'(n), longint'(2 * expK + 2));
    check(busy === 1'b0, "R6 busy low with done", longint'(busy), 0);
    @(negedge clk);
    check(done === 1'b0, "R6 done single pulse", longint'(done), 0);
    repeat (3) @(negedge clk);
    check(kOut == KW'(expK), "R7 result held", longint'(kOut), longint'(expK));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R6 reset busy", longint'(busy), 0);
    check(done === 1'b0, "R6 reset done", longint'(done), 0);
    check(kOut == '0, "R7 reset kOut", longint'(kOut), 0);
    rstN = 1'b1;

    runPoint(7 * ONE, 0, 500, "R4 far point k=1", 1'b0);
    runPoint(2 * ONE, 0, 500, "R4 radius edge c=2", 1'b0);
    runPoint(-2 * ONE, 0, 500, "R4 radius edge c=-2", 1'b0);
    runPoint(ONE / 4, 0, 0, "R3 limit zero", 1'b0);
    runPoint(-ONE, 0, 300, "R5 period-two orbit", 1'b0);
    runPoint(ONE / 2, ONE / 2, 100, "R1 interior-ish point", 1'b0);
    runPoint(-ONE, ONE / 4, 200, "R8 start while busy", 1'b1);
    runPoint(ONE / 3, -ONE / 2, 150, "R2 back-to-back clear", 1'b0);
    runPoint(0, 0, 65540, "R5 origin large limit", 1'b0);

    for (int i = 0; i < 40; i++) begin
      int cr, ci, lim;
      cr  = int'($urandom % 32'd1342177280) - 671088640;
      ci  = int'($urandom % 32'd1342177280) - 671088640;
      lim = int'($urandom_range(1, 200));
      runPoint(cr, ci, lim, "R1 random vs model", 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule